// File: doc/BRIEF.md
# ISA I/O Slave Port with Run-Time Width Qualification

This block is the slave side of an ISA I/O port. It watches the 10-bit system address and the active-low address-enable line. When the address falls inside a 16-byte window at a fixed base, it services active-low read and write strobes against eight 16-bit registers. The strobes are brought into the clock domain through two-flop synchronisers, and a command is acted on once, at the falling edge of the synchronised strobe. For every accepted command the block pulls its ready output low for two clocks. Read data goes out on a lane-split data bus with a separate output enable for each byte lane.

The block drives the open-drain 16-bit chip-select pin low purely from the address decode. It also senses that pin, together with the byte-high-enable line, to decide whether the host can handle word transfers. Word transfers are allowed only after the chip-select pin has been seen high and byte-high-enable has been seen falling, both since the last valid reset. Until then every access is a byte access on the low lane. A reset input shorter than ten clocks is filtered out. All outputs sit at their idle level while reset is high.

Top module: `isa_io_port`

## Requirements
- R1: A command is accepted only when `aen_n` is 0 and `sa[9:4]` equals the base address bits [9:4] (base 0x300 by default). A strobe under any other condition produces no ready pulse, drives no data lane and changes no register.
- R2: `cs16_drive` (1 means the pin is pulled low) equals the decode of `aen_n` and `sa[9:4]` at all times outside reset. It does not depend on the strobes.
- R3: Word transfers need `cs16_sense` to have been observed high at least once since the last valid reset. A pin that stays low keeps the block in byte mode.
- R4: Word transfers also need at least one high-to-low transition on `sbhe_n` since the last valid reset. A line held high throughout, or held low throughout, keeps the block in byte mode.
- R5: In byte mode the register index is `sa[3:1]` and `sa[0]` picks the byte (0 = bits 7:0, 1 = bits 15:8). Writes take `sd_in[7:0]`. Reads return the byte on `sd_out[7:0]` with `sd_out[15:8]` = 0, and only `sd_oe_lo` set.
- R6: With word transfers enabled and `sbhe_n` = 0: an even address moves the full word on both lanes with both enables set; an odd address moves the high byte on `sd_out[15:8]`/`sd_in[15:8]` with only `sd_oe_hi` set. With `sbhe_n` = 1 the R5 rule applies.
- R7: After a strobe falls, `iochrdy` stays high for two clocks, is low for exactly the next two clocks and then returns high. Read data and lane enables are valid from the first low clock. The enables stay set until the strobe release has passed the synchroniser.
- R8: `rst` held high for at least 10 clocks clears both qualification flags. A shorter pulse leaves them unchanged.
- R9: While `rst` is high, `iochrdy` is 1 and `sd_oe_lo`, `sd_oe_hi` and `cs16_drive` are 0.
- R10: Once word transfers are enabled they stay enabled, whatever the pins do, until the next valid reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Active-high reset request, filtered for minimum length |
| aen_n | input | 1 | Address enable, low for I/O cycles |
| sa | input | 10 | System address |
| sbhe_n | input | 1 | Byte-high-enable, active low |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| sd_in | input | 16 | Data from the bus |
| sd_out | output | 16 | Read data to the bus |
| sd_oe_lo | output | 1 | Drive enable for sd_out[7:0] |
| sd_oe_hi | output | 1 | Drive enable for sd_out[15:8] |
| cs16_drive | output | 1 | Pull the 16-bit chip-select pin low |
| cs16_sense | input | 1 | Sensed level of the 16-bit chip-select pin |
| iochrdy | output | 1 | Ready, low while a command is being serviced |

## Verification
The bound checker watches, on every clock, four things: the shape of the ready pulse, the independence of the chip-select drive from the strobes, the absence of any ready pulse while address-enable is high, and the stickiness of the width decision. It also checks idle outputs during reset and that the internal reset only follows a sustained request. Lane mapping, register contents, the need for both qualification events, and the difference between a short and a full-length reset show only in the bench's scenarios. There, reads compare the data lanes against a model that tracks the grounded-pin case, the missing-falling-edge case and each reset length.

// File: rtl/isa_io_pkg.sv
package isa_io_pkg;

  typedef enum logic [1:0] {
    XFER_LOW_LANE  = 2'd0,
    XFER_HIGH_LANE = 2'd1,
    XFER_WORD      = 2'd2
  } xfer_e;

  // Transfer shape for one command, from width state, address LSB and sbhe_n.
  function automatic xfer_e pick_xfer(input logic wide_ok, input logic a0,
                                      input logic hbe_n);
    if (wide_ok && !hbe_n) return a0 ? XFER_HIGH_LANE : XFER_WORD;
    return XFER_LOW_LANE;
  endfunction

endpackage

// File: rtl/isa_sync.sv
module isa_sync #(
  parameter int    STAGES  = 2,
  parameter logic  RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/isa_rst_filter.sv
module isa_rst_filter #(
  parameter int MIN_CYCLES = 10
) (
  input  logic clk,
  input  logic rst_req,
  output logic rst_eff
);
  localparam int CW = $clog2(MIN_CYCLES + 1);

  logic [CW-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_req) begin
      held    <= '0;
      rst_eff <= 1'b0;
    end else begin
      if (held != CW'(MIN_CYCLES)) held <= held + 1'b1;
      rst_eff <= (held >= CW'(MIN_CYCLES - 1));
    end
  end
endmodule

// File: rtl/isa_width_qual.sv
module isa_width_qual (
  input  logic clk,
  input  logic rst,
  input  logic cs16_s,
  input  logic sbhe_s,
  output logic wide_ok
);
  logic seen_high;
  logic seen_fall;
  logic sbhe_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_high <= 1'b0;
      seen_fall <= 1'b0;
      sbhe_prev <= 1'b0;
    end else begin
      sbhe_prev <= sbhe_s;
      if (cs16_s)               seen_high <= 1'b1;
      if (sbhe_prev && !sbhe_s) seen_fall <= 1'b1;
    end
  end

  assign wide_ok = seen_high & seen_fall;
endmodule

// File: rtl/isa_regfile.sv
module isa_regfile #(
  parameter int NREG   = 8,
  parameter int BYTE_W = 8,
  localparam int IDX_W  = $clog2(NREG),
  localparam int DATA_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic [1:0]        we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  generate
    for (genvar l = 0; l < 2; l++) begin : g_lane
      logic [BYTE_W-1:0] bank [NREG];
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk) begin
        if (we[l]) bank[waddr] <= wdata[l*BYTE_W +: BYTE_W];
        q <= bank[raddr];
      end
      assign rdata[l*BYTE_W +: BYTE_W] = q;
    end
  endgenerate
endmodule

// File: rtl/isa_io_port.sv
module isa_io_port #(
  parameter int          ADDR_W      = 10,
  parameter int          DATA_W      = 16,
  parameter int          NREG        = 8,
  parameter logic [9:0]  BASE_ADDR   = 10'h300,
  parameter int          RST_MIN     = 10,
  parameter int          SYNC_STAGES = 2,
  parameter int          RDY_LOW     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aen_n,
  input  logic [ADDR_W-1:0] sa,
  input  logic              sbhe_n,
  input  logic              ior_n,
  input  logic              iow_n,
  input  logic [DATA_W-1:0] sd_in,
  output logic [DATA_W-1:0] sd_out,
  output logic              sd_oe_lo,
  output logic              sd_oe_hi,
  output logic              cs16_drive,
  input  logic              cs16_sense,
  output logic              iochrdy
);
  import isa_io_pkg::*;

  localparam int BYTE_W  = DATA_W / 2;
  localparam int IDX_W   = $clog2(NREG);
  localparam int WIN_LSB = IDX_W + 1;
  localparam int CNT_W   = $clog2(RDY_LOW + 1);

  logic rst_eff;
  logic ior_s, iow_s, cs16_s, sbhe_s;
  logic ior_p, iow_p;
  logic wide_ok;

  isa_rst_filter #(.MIN_CYCLES(RST_MIN)) u_rst (
    .clk(clk), .rst_req(rst), .rst_eff(rst_eff)
  );

  isa_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rd (
    .clk(clk), .rst(rst_eff), .d(ior_n), .q(ior_s)
  );
  isa_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_wr (
    .clk(clk), .rst(rst_eff), .d(iow_n), .q(iow_s)
  );
  isa_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_cs (
    .clk(clk), .rst(rst_eff), .d(cs16_sense), .q(cs16_s)
  );
  isa_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_hbe (
    .clk(clk), .rst(rst_eff), .d(sbhe_n), .q(sbhe_s)
  );

  isa_width_qual u_width (
    .clk(clk), .rst(rst_eff), .cs16_s(cs16_s), .sbhe_s(sbhe_s), .wide_ok(wide_ok)
  );

  // Address decode: window of 2*NREG bytes at the base.
  logic hit_now;
  assign hit_now    = !aen_n &&
                      (sa[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
  assign cs16_drive = hit_now & ~rst;

  // Command edge detection on the synchronised strobes.
  always_ff @(posedge clk) begin
    if (rst_eff) begin
      ior_p <= 1'b1;
      iow_p <= 1'b1;
    end else begin
      ior_p <= ior_s;
      iow_p <= iow_s;
    end
  end

  logic act_rd, act_wr, act_any;
  assign act_rd  = ior_p & ~ior_s & hit_now;
  assign act_wr  = iow_p & ~iow_s & hit_now;
  assign act_any = act_rd | act_wr;

  xfer_e            xfer;
  logic [IDX_W-1:0] idx;
  assign xfer = pick_xfer(wide_ok, sa[0], sbhe_n);
  assign idx  = sa[IDX_W:1];

  // Register file write lanes.
  logic [1:0]        we;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rword;

  always_comb begin
    we    = 2'b00;
    wdata = {sd_in[BYTE_W-1:0], sd_in[BYTE_W-1:0]};
    unique case (xfer)
      XFER_WORD: begin
        we    = {act_wr, act_wr};
        wdata = sd_in;
      end
      XFER_HIGH_LANE: begin
        we    = {act_wr, 1'b0};
        wdata = {sd_in[DATA_W-1:BYTE_W], sd_in[BYTE_W-1:0]};
      end
      default: begin
        we = sa[0] ? {act_wr, 1'b0} : {1'b0, act_wr};
      end
    endcase
  end

  isa_regfile #(.NREG(NREG), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .we(we), .waddr(idx), .wdata(wdata), .raddr(idx), .rdata(rword)
  );

  // Read data, lane enables and ready counter.
  logic [DATA_W-1:0] dout_q;
  logic              oe_lo_q, oe_hi_q;
  logic [CNT_W-1:0]  rdy_cnt;

  always_ff @(posedge clk) begin
    if (rst_eff) begin
      dout_q  <= '0;
      oe_lo_q <= 1'b0;
      oe_hi_q <= 1'b0;
    end else if (act_rd) begin
      unique case (xfer)
        XFER_WORD: begin
          dout_q  <= rword;
          oe_lo_q <= 1'b1;
          oe_hi_q <= 1'b1;
        end
        XFER_HIGH_LANE: begin
          dout_q  <= {rword[DATA_W-1:BYTE_W], {BYTE_W{1'b0}}};
          oe_lo_q <= 1'b0;
          oe_hi_q <= 1'b1;
        end
        default: begin
          dout_q  <= {{BYTE_W{1'b0}},
                      (sa[0] ? rword[DATA_W-1:BYTE_W] : rword[BYTE_W-1:0])};
          oe_lo_q <= 1'b1;
          oe_hi_q <= 1'b0;
        end
      endcase
    end else if (ior_s) begin
      oe_lo_q <= 1'b0;
      oe_hi_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_eff)             rdy_cnt <= '0;
    else if (act_any)        rdy_cnt <= CNT_W'(RDY_LOW);
    else if (rdy_cnt != '0)  rdy_cnt <= rdy_cnt - 1'b1;
  end

  assign sd_out   = dout_q;
  assign sd_oe_lo = oe_lo_q & ~rst;
  assign sd_oe_hi = oe_hi_q & ~rst;
  assign iochrdy  = (rdy_cnt == '0) | rst;

endmodule

// File: rtl/isa_io_port_chk.sv
module isa_io_port_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              rst_eff,
  input logic              aen_n,
  input logic [ADDR_W-1:0] sa,
  input logic              cs16_drive,
  input logic              iochrdy,
  input logic              sd_oe_lo,
  input logic              sd_oe_hi,
  input logic              wide_ok,
  input logic              act_any
);
  // R1: no ready pulse while address-enable was high in the two deciding cycles
  assert_miss_no_ready_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(aen_n) && $past(aen_n, 2)) |-> iochrdy);

  // R2: chip-select drive follows only the address and address-enable
  assert_cs16_strobe_free_R2: assert property (@(posedge clk) disable iff (rst)
    ($stable(sa) && $stable(aen_n) && !$past(rst)) |-> $stable(cs16_drive));

  // R7: ready low lasts at least two clocks and stems from a recent command
  assert_rdy_two_low_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(iochrdy) |=> !iochrdy);
  assert_rdy_has_cause_R7: assert property (@(posedge clk) disable iff (rst)
    !iochrdy |-> ($past(act_any) || $past(act_any, 2)));

  // R6: a lane enable turns on together with the ready pulse
  assert_oe_with_ready_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(sd_oe_lo) || $rose(sd_oe_hi)) |-> !iochrdy);

  // R8: internal reset only follows a held request
  assert_filter_follows_R8: assert property (@(posedge clk)
    rst_eff |-> $past(rst));

  // R9: idle outputs during reset
  assert_idle_in_reset_R9: assert property (@(posedge clk)
    rst |-> (iochrdy && !sd_oe_lo && !sd_oe_hi && !cs16_drive));

  // R10: width decision is sticky
  assert_wide_sticky_R10: assert property (@(posedge clk) disable iff (rst_eff)
    $past(wide_ok) |-> wide_ok);
endmodule

bind isa_io_port isa_io_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .rst_eff(rst_eff), .aen_n(aen_n), .sa(sa),
  .cs16_drive(cs16_drive), .iochrdy(iochrdy), .sd_oe_lo(sd_oe_lo),
  .sd_oe_hi(sd_oe_hi), .wide_ok(wide_ok), .act_any(act_any)
);

// File: tb/isa_io_port_test.sv
`timescale 1ns/1ps
module isa_io_port_test;
  localparam logic [9:0] BASE = 10'h300;

  logic        clk = 1'b0;
  logic        rst, aen_n, sbhe_n, ior_n, iow_n, pull_q;
  logic [9:0]  sa;
  logic [15:0] sd_in;
  logic [15:0] sd_out;
  logic        sd_oe_lo, sd_oe_hi, cs16_drive, iochrdy, cs16_sense;

  int nchecks = 0;
  int nerr    = 0;

  logic [15:0] model_mem [8];
  bit m_seen, m_fell;

  always #10 clk = ~clk;

  assign cs16_sense = cs16_drive ? 1'b0 : pull_q;

  isa_io_port uut (
    .clk(clk), .rst(rst), .aen_n(aen_n), .sa(sa), .sbhe_n(sbhe_n),
    .ior_n(ior_n), .iow_n(iow_n), .sd_in(sd_in), .sd_out(sd_out),
    .sd_oe_lo(sd_oe_lo), .sd_oe_hi(sd_oe_hi), .cs16_drive(cs16_drive),
    .cs16_sense(cs16_sense), .iochrdy(iochrdy)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_wide();
    return m_seen && m_fell;
  endfunction

  // One bus cycle; checks ready shape, lanes and read data against the model.
  task automatic io_cycle(input bit wr, input logic [9:0] addr,
                          input logic [15:0] wdata, input bit en_n,
                          input string req);
    bit          hit;
    logic [4:0]  pat;
    logic [15:0] dcap, w, exp_d;
    logic        lo_cap, hi_cap, exp_lo, exp_hi;
    logic [2:0]  idx;
    int          kind; // 0 low lane, 1 high lane, 2 word
    hit  = !en_n && (addr[9:4] == BASE[9:4]);
    idx  = addr[3:1];
    kind = (exp_wide() && !sbhe_n) ? (addr[0] ? 1 : 2) : 0;
    pat  = '0;
    dcap = '0; lo_cap = 1'b0; hi_cap = 1'b0;
    @(negedge clk);
    aen_n = en_n; sa = addr; sd_in = wdata;
    @(negedge clk);
    if (wr) iow_n = 1'b0; else ior_n = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      pat = {pat[3:0], iochrdy};
      if (k == 3) begin dcap = sd_out; lo_cap = sd_oe_lo; hi_cap = sd_oe_hi; end
    end
    chk(pat == (hit ? 5'b11001 : 5'b11111), {req, " R7 ready shape"},
        32'(pat), 32'(hit ? 5'b11001 : 5'b11111));
    w = model_mem[idx];
    if (!wr) begin
      exp_lo = 1'b0; exp_hi = 1'b0; exp_d = dcap;
      if (hit) begin
        case (kind)
          2:       begin exp_d = w;                  exp_lo = 1; exp_hi = 1; end
          1:       begin exp_d = {w[15:8], 8'h00};   exp_hi = 1; end
          default: begin exp_d = {8'h00, addr[0] ? w[15:8] : w[7:0]}; exp_lo = 1; end
        endcase
      end
      chk({lo_cap, hi_cap} == {exp_lo, exp_hi}, {req, " lane enables"},
          32'({lo_cap, hi_cap}), 32'({exp_lo, exp_hi}));
      chk(dcap == exp_d, {req, " read data"}, 32'(dcap), 32'(exp_d));
    end else if (hit) begin
      case (kind)
        2:       model_mem[idx] = wdata;
        1:       model_mem[idx][15:8] = wdata[15:8];
        default: if (addr[0]) model_mem[idx][15:8] = wdata[7:0];
                 else         model_mem[idx][7:0]  = wdata[7:0];
      endcase
    end
    ior_n = 1'b1; iow_n = 1'b1; aen_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!sd_oe_lo && !sd_oe_hi, "R7 enables released",
        32'({sd_oe_lo, sd_oe_hi}), 32'(0));
  endtask

  task automatic set_sbhe(input logic v);
    logic last;
    @(negedge clk);
    last   = sbhe_n;
    sbhe_n = v;
    repeat (4) @(negedge clk);
    if (last && !v) m_fell = 1'b1;
  endtask

  task automatic set_pull(input logic v);
    @(negedge clk);
    pull_q = v;
    repeat (4) @(negedge clk);
    if (v) m_seen = 1'b1;
  endtask

  task automatic do_reset(input int cycles);
    @(negedge clk);
    rst = 1'b1; aen_n = 1'b1;
    repeat (cycles) @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    if (cycles >= 10) begin
      m_fell = 1'b0;
      m_seen = pull_q;
    end
  endtask

  task automatic rand_op(input string req, input int en_pct);
    logic [2:0]  idx;
    logic        a0, wr, en_n;
    logic [15:0] d;
    idx  = 3'($urandom_range(0, 7));
    a0   = 1'($urandom_range(0, 1));
    wr   = 1'($urandom_range(0, 1));
    d    = 16'($urandom);
    en_n = ($urandom_range(0, 99) < en_pct) ? 1'b0 : 1'b1;
    io_cycle(wr, BASE + {6'd0, idx, a0}, d, en_n, req);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nchecks++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h15A0_0960);
    rst = 1'b1; aen_n = 1'b0; sa = BASE; sbhe_n = 1'b1;
    ior_n = 1'b1; iow_n = 1'b1; sd_in = '0; pull_q = 1'b0;
    m_seen = 1'b0; m_fell = 1'b0;
    for (int i = 0; i < 8; i++) model_mem[i] = '0;

    // R9: idle outputs in reset even with a matching address
    repeat (12) @(negedge clk);
    chk(iochrdy && !sd_oe_lo && !sd_oe_hi && !cs16_drive, "R9 idle in reset",
        32'({iochrdy, sd_oe_lo, sd_oe_hi, cs16_drive}), 32'(4'b1000));
    aen_n = 1'b1;
    rst = 1'b0;
    repeat (6) @(negedge clk);

    // R5: byte mode, initialise every byte then random byte traffic
    for (int i = 0; i < 16; i++)
      io_cycle(1'b1, BASE + 10'(i), 16'($urandom), 1'b0, "R5 init");
    for (int i = 0; i < 16; i++)
      io_cycle(1'b0, BASE + 10'(i), 16'h0, 1'b0, "R5 readback");
    for (int i = 0; i < 20; i++) rand_op("R5 random", 90);

    // R2: chip-select decode with random strobes
    for (int i = 0; i < 40; i++) begin
      logic exp_cs;
      @(negedge clk);
      aen_n = 1'($urandom_range(0, 1));
      sa    = ($urandom_range(0, 1) == 1) ? (BASE | 10'($urandom_range(0, 15)))
                                          : 10'($urandom);
      ior_n = 1'($urandom_range(0, 1));
      #1;
      exp_cs = !aen_n && (sa[9:4] == BASE[9:4]);
      chk(cs16_drive == exp_cs, "R2 decode", 32'(cs16_drive), 32'(exp_cs));
    end
    ior_n = 1'b1; aen_n = 1'b1;
    repeat (6) @(negedge clk);

    // R3: sbhe fell but chip-select pin grounded -> still byte mode
    set_sbhe(1'b0);
    io_cycle(1'b1, BASE + 10'd4, 16'hABCD, 1'b0, "R3 grounded word write");
    io_cycle(1'b0, BASE + 10'd4, 16'h0,    1'b0, "R3 grounded word read");

    // R1: misses leave registers untouched
    io_cycle(1'b1, BASE + 10'd6, 16'h5A5A, 1'b1, "R1 aen high write");
    io_cycle(1'b1, 10'h2F6,      16'h5A5A, 1'b0, "R1 wrong base write");
    io_cycle(1'b0, BASE + 10'd6, 16'h0,    1'b1, "R1 aen high read");
    io_cycle(1'b0, BASE + 10'd6, 16'h0,    1'b0, "R1 readback");
    io_cycle(1'b0, BASE + 10'd7, 16'h0,    1'b0, "R1 readback");

    // R6: pin seen high -> word mode
    set_pull(1'b1);
    io_cycle(1'b1, BASE + 10'd8, 16'h1234, 1'b0, "R6 word write");
    io_cycle(1'b0, BASE + 10'd8, 16'h0,    1'b0, "R6 word read");
    io_cycle(1'b1, BASE + 10'd9, 16'hBE00, 1'b0, "R6 high lane write");
    io_cycle(1'b0, BASE + 10'd9, 16'h0,    1'b0, "R6 high lane read");
    set_sbhe(1'b1);
    io_cycle(1'b0, BASE + 10'd8, 16'h0,    1'b0, "R6 sbhe high byte read");
    for (int i = 0; i < 30; i++) begin
      if (i % 6 == 0) set_sbhe(1'($urandom_range(0, 1)));
      rand_op("R6 random", 85);
    end

    // R8: short pulse keeps word mode
    set_sbhe(1'b0);
    do_reset(5);
    io_cycle(1'b1, BASE + 10'd2, 16'hC0DE, 1'b0, "R8 short pulse write");
    io_cycle(1'b0, BASE + 10'd2, 16'h0,    1'b0, "R8 short pulse read");

    // R4/R8: full reset with sbhe held low -> no falling edge -> byte mode
    do_reset(12);
    io_cycle(1'b1, BASE + 10'd10, 16'hF00D, 1'b0, "R4 no fall write");
    io_cycle(1'b0, BASE + 10'd10, 16'h0,    1'b0, "R4 no fall read");

    // R10: qualify again, then ground the pin; mode must stay wide
    set_sbhe(1'b1);
    set_sbhe(1'b0);
    set_pull(1'b0);
    io_cycle(1'b1, BASE + 10'd12, 16'h7E57, 1'b0, "R10 sticky write");
    io_cycle(1'b0, BASE + 10'd12, 16'h0,    1'b0, "R10 sticky read");
    set_sbhe(1'b1);
    set_sbhe(1'b0);
    io_cycle(1'b0, BASE + 10'd12, 16'h0,    1'b0, "R10 sticky after toggle");

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end
endmodule